// File: doc/BRIEF.md
# Processor exception entry controller

This block holds the control state a small 32-bit RISC core needs when it takes an exception or returns from one. A single-cycle request carries a 3-bit cause code and the program counter of the faulting instruction. On the following clock edge the block saves that counter into one of two link registers, updates the interrupt-enable bits, and presents a new fetch address together with a one-cycle redirect strobe.

Causes fall into two classes. Breakpoint and watchpoint form the debug class. All other codes form the normal class. Each class has its own link register and its own saved-enable bit. Every cause owns a 32-byte slot in a vector table. The table starts at the normal base or at the debug base. A remap control bit can steer the normal class to the debug base. Two return operations restore the global enable from the matching saved bit and send fetch back through the matching link register.

A small register-write port loads both base registers, the remap bit and the enable bits. The base registers keep only their upper bits, so the vector table is always aligned.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, IE, EIE, BIE and the remap bit are 0, both bases read 0, fetch_pc is 0 (the reset normal base) and redirect is 0.
- R2: Cause codes are 0 reset, 1 breakpoint, 2 instruction bus error, 3 watchpoint, 4 data bus error, 5 divide by zero, 6 interrupt and 7 system call. Codes 1 and 3 are the debug class and all other codes are the normal class. The vector target is base + cause*32.
- R3: A normal-class request writes cur_pc into the exception link register (ea_o) and clears IE. It sets EIE if IE was 1 and otherwise leaves EIE unchanged. BIE does not change.
- R4: A debug-class request writes cur_pc into the breakpoint link register (ba_o) and clears IE. It sets BIE if IE was 1 and otherwise leaves BIE unchanged. EIE does not change.
- R5: A normal-class request vectors from the normal base when the remap bit is 0 and from the debug base when it is 1.
- R6: A debug-class request always vectors from the debug base, whatever the remap bit is.
- R7: A return-from-exception copies EIE into IE and redirects fetch to ea_o.
- R8: A return-from-breakpoint copies BIE into IE and redirects fetch to ba_o.
- R9: Register writes decode wr_addr: 0 writes the normal base, 1 writes the debug base, 2 writes the remap bit from wr_data[0], and 3 writes IE, EIE and BIE from wr_data[0], [1] and [2]. The low 8 bits of each base always read 0.
- R10: In one cycle, exc_req wins over ret_exc, and ret_exc wins over ret_brk. A status write (address 3) is ignored in any cycle that has an exception or a return.
- R11: Every accepted request or return updates fetch_pc and raises redirect for exactly the next cycle. In cycles without one, fetch_pc holds and redirect is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_req | input | 1 | One-cycle exception request |
| exc_cause | input | 3 | Cause code of the request |
| cur_pc | input | 32 | Program counter to save |
| ret_exc | input | 1 | Return-from-exception operation |
| ret_brk | input | 1 | Return-from-breakpoint operation |
| wr_en | input | 1 | Register-write enable |
| wr_addr | input | 2 | Register-write address |
| wr_data | input | 32 | Register-write data |
| fetch_pc | output | 32 | Redirected fetch address |
| redirect | output | 1 | fetch_pc was just loaded |
| ie_o | output | 1 | Global interrupt enable |
| eie_o | output | 1 | Enable saved by a normal exception |
| bie_o | output | 1 | Enable saved by a debug exception |
| remap_o | output | 1 | Remap normal class to debug base |
| ea_o | output | 32 | Exception link register |
| ba_o | output | 32 | Breakpoint link register |
| nbase_o | output | 32 | Normal vector base |
| dbase_o | output | 32 | Debug vector base |

## Verification
Assertions check the following properties on every cycle:
- the enable save and clear for both classes, and the restore on each return;
- link capture;
- debug-class vectoring from the debug base;
- the one-cycle redirect and the holding of fetch_pc while idle;
- base alignment.

Only the bench's scenarios show the exact vector arithmetic for particular causes, and the remap steering of normal causes. They also show the decode of each write address and the outcome of simultaneous requests, such as a status write that loses to a return.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int CAUSE_W = 3;

   typedef enum logic [CAUSE_W-1:0] {
      CAUSE_RESET = 3'd0,
      CAUSE_BKPT  = 3'd1,
      CAUSE_IBUS  = 3'd2,
      CAUSE_WATCH = 3'd3,
      CAUSE_DBUS  = 3'd4,
      CAUSE_DIV0  = 3'd5,
      CAUSE_IRQ   = 3'd6,
      CAUSE_SCALL = 3'd7
   } cause_e;

   typedef enum logic [1:0] {
      WA_NBASE = 2'd0,
      WA_DBASE = 2'd1,
      WA_CTRL  = 2'd2,
      WA_STAT  = 2'd3
   } waddr_e;

   function automatic logic is_debug_cause(input logic [CAUSE_W-1:0] c);
      return (c == CAUSE_BKPT) || (c == CAUSE_WATCH);
   endfunction
endpackage

// File: rtl/exc_base_regs.sv
module exc_base_regs
   import exc_entry_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int ALIGN_BITS = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [XLEN-1:0] wr_data,
   output logic [XLEN-1:0] nbase_o,
   output logic [XLEN-1:0] dbase_o,
   output logic            remap_o
);
   localparam int HI_W = XLEN - ALIGN_BITS;
   localparam int NBASES = 2;

   logic [HI_W-1:0] base_hi [NBASES];
   logic            remap_q;

   for (genvar g = 0; g < NBASES; g++) begin : g_base
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_hi[g] <= '0;
         else if (wr_en && (wr_addr == 2'(g)))
            base_hi[g] <= wr_data[XLEN-1:ALIGN_BITS];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         remap_q <= 1'b0;
      else if (wr_en && (wr_addr == WA_CTRL))
         remap_q <= wr_data[0];
   end

   assign nbase_o = {base_hi[0], {ALIGN_BITS{1'b0}}};
   assign dbase_o = {base_hi[1], {ALIGN_BITS{1'b0}}};
   assign remap_o = remap_q;

   // R9: vector table alignment
   always_comb begin
      a_r9_base_aligned: assert (nbase_o[ALIGN_BITS-1:0] == '0 && dbase_o[ALIGN_BITS-1:0] == '0);
   end
endmodule

// File: rtl/exc_status.sv
module exc_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       take_norm,
   input  logic       take_dbg,
   input  logic       do_rete,
   input  logic       do_retb,
   input  logic       st_we,
   input  logic [2:0] st_wdata,
   output logic       ie_o,
   output logic       eie_o,
   output logic       bie_o
);
   logic ie_q, eie_q, bie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         eie_q <= 1'b0;
         bie_q <= 1'b0;
      end else if (take_norm) begin
         eie_q <= eie_q | ie_q;
         ie_q  <= 1'b0;
      end else if (take_dbg) begin
         bie_q <= bie_q | ie_q;
         ie_q  <= 1'b0;
      end else if (do_rete) begin
         ie_q <= eie_q;
      end else if (do_retb) begin
         ie_q <= bie_q;
      end else if (st_we) begin
         ie_q  <= st_wdata[0];
         eie_q <= st_wdata[1];
         bie_q <= st_wdata[2];
      end
   end

   assign ie_o  = ie_q;
   assign eie_o = eie_q;
   assign bie_o = bie_q;

   // R3
   a_r3_normal_saves_ie: assert property (@(posedge clk) disable iff (!rst_n)
      take_norm |=> (!ie_q && eie_q == $past(eie_q | ie_q) && bie_q == $past(bie_q)));
   // R4
   a_r4_debug_saves_ie: assert property (@(posedge clk) disable iff (!rst_n)
      take_dbg |=> (!ie_q && bie_q == $past(bie_q | ie_q) && eie_q == $past(eie_q)));
   // R7
   a_r7_rete_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (do_rete && !take_norm && !take_dbg) |=> ie_q == $past(eie_q));
   // R8
   a_r8_retb_restores: assert property (@(posedge clk) disable iff (!rst_n)
      (do_retb && !do_rete && !take_norm && !take_dbg) |=> ie_q == $past(bie_q));
endmodule

// File: rtl/exc_target.sv
module exc_target
   import exc_entry_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int SLOT_SHIFT = 5,
   parameter int ALIGN_BITS = 8
) (
   input  logic [CAUSE_W-1:0] cause,
   input  logic               remap,
   input  logic [XLEN-1:0]    nbase,
   input  logic [XLEN-1:0]    dbase,
   output logic [XLEN-1:0]    target
);
   localparam int OFS_W  = CAUSE_W + SLOT_SHIFT;
   localparam bit OR_OK  = (ALIGN_BITS >= OFS_W);

   logic [XLEN-1:0] base_sel;
   logic [XLEN-1:0] offset;

   assign base_sel = (is_debug_cause(cause) || remap) ? dbase : nbase;
   assign offset   = XLEN'({cause, {SLOT_SHIFT{1'b0}}});

   if (OR_OK) begin : g_merge
      assign target = base_sel | offset;
   end else begin : g_add
      assign target = base_sel + offset;
   end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_entry_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int SLOT_SHIFT = 5,
   parameter int ALIGN_BITS = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               exc_req,
   input  logic [2:0]         exc_cause,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic               ret_exc,
   input  logic               ret_brk,
   input  logic               wr_en,
   input  logic [1:0]         wr_addr,
   input  logic [XLEN-1:0]    wr_data,
   output logic [XLEN-1:0]    fetch_pc,
   output logic               redirect,
   output logic               ie_o,
   output logic               eie_o,
   output logic               bie_o,
   output logic               remap_o,
   output logic [XLEN-1:0]    ea_o,
   output logic [XLEN-1:0]    ba_o,
   output logic [XLEN-1:0]    nbase_o,
   output logic [XLEN-1:0]    dbase_o
);
   if (ALIGN_BITS < 1 || ALIGN_BITS >= XLEN) begin : g_bad_align
      $error("ALIGN_BITS must lie in 1..XLEN-1");
   end
   if (CAUSE_W + SLOT_SHIFT >= XLEN) begin : g_bad_slot
      $error("vector offset does not fit in XLEN");
   end

   logic            dbg_cls;
   logic            take_norm, take_dbg, do_rete, do_retb, st_we;
   logic [XLEN-1:0] vec_target;
   logic [XLEN-1:0] ea_q, ba_q, fetch_q;
   logic            redir_q;

   assign dbg_cls   = is_debug_cause(exc_cause);
   assign take_norm = exc_req && !dbg_cls;
   assign take_dbg  = exc_req && dbg_cls;
   assign do_rete   = ret_exc && !exc_req;
   assign do_retb   = ret_brk && !exc_req && !ret_exc;
   assign st_we     = wr_en && (wr_addr == WA_STAT) && !exc_req && !ret_exc && !ret_brk;

   exc_base_regs #(.XLEN(XLEN), .ALIGN_BITS(ALIGN_BITS)) u_bases (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .nbase_o(nbase_o), .dbase_o(dbase_o), .remap_o(remap_o)
   );

   exc_status u_status (
      .clk(clk), .rst_n(rst_n), .take_norm(take_norm), .take_dbg(take_dbg),
      .do_rete(do_rete), .do_retb(do_retb), .st_we(st_we), .st_wdata(wr_data[2:0]),
      .ie_o(ie_o), .eie_o(eie_o), .bie_o(bie_o)
   );

   exc_target #(.XLEN(XLEN), .SLOT_SHIFT(SLOT_SHIFT), .ALIGN_BITS(ALIGN_BITS)) u_target (
      .cause(exc_cause), .remap(remap_o), .nbase(nbase_o), .dbase(dbase_o), .target(vec_target)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ea_q    <= '0;
         ba_q    <= '0;
         fetch_q <= '0;
         redir_q <= 1'b0;
      end else begin
         redir_q <= exc_req || ret_exc || ret_brk;
         if (take_norm) ea_q <= cur_pc;
         if (take_dbg)  ba_q <= cur_pc;
         if (exc_req)      fetch_q <= vec_target;
         else if (do_rete) fetch_q <= ea_q;
         else if (do_retb) fetch_q <= ba_q;
      end
   end

   assign fetch_pc = fetch_q;
   assign redirect = redir_q;
   assign ea_o     = ea_q;
   assign ba_o     = ba_q;

   // R3
   a_r3_ea_link: assert property (@(posedge clk) disable iff (!rst_n)
      take_norm |=> ea_q == $past(cur_pc));
   // R4
   a_r4_ba_link: assert property (@(posedge clk) disable iff (!rst_n)
      take_dbg |=> ba_q == $past(cur_pc));
   // R6
   a_r6_debug_base: assert property (@(posedge clk) disable iff (!rst_n)
      take_dbg |=> fetch_q == $past(dbase_o) + XLEN'($past(exc_cause)) * (XLEN'(1) << SLOT_SHIFT));
   // R7
   a_r7_rete_target: assert property (@(posedge clk) disable iff (!rst_n)
      do_rete |=> fetch_q == $past(ea_q));
   // R8
   a_r8_retb_target: assert property (@(posedge clk) disable iff (!rst_n)
      do_retb |=> fetch_q == $past(ba_q));
   // R11
   a_r11_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_req || ret_exc || ret_brk) |=> redir_q);
   a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(exc_req || ret_exc || ret_brk) |=> (!redir_q && fetch_q == $past(fetch_q)));
endmodule

// File: tb/exc_entry_ctrl_test.sv
module exc_entry_ctrl_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        exc_req = 0, ret_exc = 0, ret_brk = 0, wr_en = 0;
   logic [2:0]  exc_cause = 0;
   logic [31:0] cur_pc = 0, wr_data = 0;
   logic [1:0]  wr_addr = 0;
   logic [31:0] fetch_pc, ea_o, ba_o, nbase_o, dbase_o;
   logic        redirect, ie_o, eie_o, bie_o, remap_o;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_ctrl uut (
      .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .exc_cause(exc_cause), .cur_pc(cur_pc),
      .ret_exc(ret_exc), .ret_brk(ret_brk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fetch_pc(fetch_pc), .redirect(redirect), .ie_o(ie_o), .eie_o(eie_o), .bie_o(bie_o),
      .remap_o(remap_o), .ea_o(ea_o), .ba_o(ba_o), .nbase_o(nbase_o), .dbase_o(dbase_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle of stimulus, driven at a falling edge and sampled at the next
   task automatic step(input logic e, input logic [2:0] c, input logic [31:0] pc,
                       input logic re, input logic rb,
                       input logic we, input logic [1:0] wa, input logic [31:0] wd);
      exc_req = e; exc_cause = c; cur_pc = pc; ret_exc = re; ret_brk = rb;
      wr_en = we; wr_addr = wa; wr_data = wd;
      @(negedge clk);
      exc_req = 0; ret_exc = 0; ret_brk = 0; wr_en = 0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      step(0, 0, 0, 0, 0, 1, a, d);
   endtask

   task automatic exc(input logic [2:0] c, input logic [31:0] pc);
      step(1, c, pc, 0, 0, 0, 0, 0);
   endtask

   task automatic t_reset;
      chk("R1 ie", {31'b0, ie_o}, 0);
      chk("R1 eie", {31'b0, eie_o}, 0);
      chk("R1 bie", {31'b0, bie_o}, 0);
      chk("R1 remap", {31'b0, remap_o}, 0);
      chk("R1 nbase", nbase_o, 0);
      chk("R1 dbase", dbase_o, 0);
      chk("R1 fetch", fetch_pc, 0);
      chk("R1 redirect", {31'b0, redirect}, 0);
   endtask

   task automatic t_writes;
      wr(0, 32'h0001_23FF);
      chk("R9 nbase low bits zero", nbase_o, 32'h0001_2300);
      wr(1, 32'h8000_0055);
      chk("R9 dbase low bits zero", dbase_o, 32'h8000_0000);
      wr(2, 32'h1);
      chk("R9 remap set", {31'b0, remap_o}, 1);
      wr(2, 32'h0);
      chk("R9 remap clear", {31'b0, remap_o}, 0);
      wr(3, 32'h5);
      chk("R9 status", {29'b0, bie_o, eie_o, ie_o}, 3'b101);
      chk("R11 no redirect on write", {31'b0, redirect}, 0);
   endtask

   task automatic t_normal;
      wr(3, 32'h1);
      exc(3'd6, 32'h0000_1000);
      chk("R2 R5 irq target", fetch_pc, 32'h0001_23C0);
      chk("R3 ea", ea_o, 32'h1000);
      chk("R3 ie/eie/bie", {29'b0, bie_o, eie_o, ie_o}, 3'b010);
      chk("R11 redirect", {31'b0, redirect}, 1);
      @(negedge clk);
      chk("R11 redirect one cycle", {31'b0, redirect}, 0);
      chk("R11 fetch holds", fetch_pc, 32'h0001_23C0);
      exc(3'd2, 32'h0000_2000);
      chk("R2 ibus target", fetch_pc, 32'h0001_2340);
      chk("R3 eie kept when ie clear", {29'b0, bie_o, eie_o, ie_o}, 3'b010);
      wr(3, 32'h0);
      exc(3'd5, 32'h0000_2100);
      chk("R3 eie stays 0", {31'b0, eie_o}, 0);
      chk("R2 div0 target", fetch_pc, 32'h0001_23A0);
      exc(3'd0, 32'h0000_7000);
      chk("R2 reset code normal class", fetch_pc, 32'h0001_2300);
      chk("R2 reset code uses ea", ea_o, 32'h7000);
   endtask

   task automatic t_debug;
      wr(3, 32'h1);
      exc(3'd3, 32'h0000_3000);
      chk("R6 watch target", fetch_pc, 32'h8000_0060);
      chk("R4 ba", ba_o, 32'h3000);
      chk("R4 ea untouched", ea_o, 32'h7000);
      chk("R4 ie/eie/bie", {29'b0, bie_o, eie_o, ie_o}, 3'b100);
   endtask

   task automatic t_remap;
      wr(2, 32'h1);
      wr(3, 32'h1);
      exc(3'd7, 32'h0000_4000);
      chk("R5 remapped scall", fetch_pc, 32'h8000_00E0);
      chk("R5 ea", ea_o, 32'h4000);
      exc(3'd1, 32'h0000_5000);
      chk("R6 bkpt with remap", fetch_pc, 32'h8000_0020);
      chk("R6 ba", ba_o, 32'h5000);
   endtask

   task automatic t_returns;
      wr(3, 32'h4);
      step(0, 0, 0, 1, 0, 0, 0, 0);
      chk("R7 ie from eie", {31'b0, ie_o}, 0);
      chk("R7 fetch ea", fetch_pc, 32'h4000);
      chk("R7 redirect", {31'b0, redirect}, 1);
      step(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R8 ie from bie", {31'b0, ie_o}, 1);
      chk("R8 fetch ba", fetch_pc, 32'h5000);
   endtask

   task automatic t_priority;
      wr(3, 32'h2);
      step(1, 3'd4, 32'h0000_6000, 1, 0, 0, 0, 0);
      chk("R10 exc over ret target", fetch_pc, 32'h8000_0080);
      chk("R10 exc over ret ea", ea_o, 32'h6000);
      chk("R10 exc over ret bits", {29'b0, bie_o, eie_o, ie_o}, 3'b010);
      wr(3, 32'h4);
      step(0, 0, 0, 1, 1, 0, 0, 0);
      chk("R10 rete over retb ie", {31'b0, ie_o}, 0);
      chk("R10 rete over retb fetch", fetch_pc, 32'h6000);
      step(0, 0, 0, 0, 1, 1, 2'd3, 32'h3);
      chk("R10 status write ignored", {29'b0, bie_o, eie_o, ie_o}, 3'b101);
      @(negedge clk);
      chk("R11 idle redirect low", {31'b0, redirect}, 0);
      chk("R11 idle fetch holds", fetch_pc, 32'h5000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      @(negedge clk);
      t_writes;
      t_normal;
      t_debug;
      t_remap;
      t_returns;
      t_priority;
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule